// File: doc/BRIEF.md
# Audio Codec Register Access Controller

This block is the register front end of an audio codec interface. A simple memory-mapped slave bus reaches it with single-cycle, full-word accesses, and it decodes them into eleven word slots. The slots hold a codec access control word, the codec register address, the outgoing and incoming codec data, and a control word, buffer address and remaining count for both the playback channel and the capture channel. Bit 0 of each channel control word is sent out as that channel's enable. The serial link and the DMA engines sit outside the block.

Writing the codec control word with its launch bit set starts a codec register transaction. One clock later the block raises a one-cycle request strobe towards the link logic, along with the stored codec address, the outgoing data and the direction. In the same cycle it pulses one of two interrupts: the request-sent line for a write transaction, or the reply line for a read transaction. The launch bit never stays stored. When the link returns a reply strobe, the returned value is loaded into the incoming-data slot.

A small state machine handles the launch. Its states are IDLE (nothing pending) and SEND (request strobe and interrupt driven for this cycle). Its transitions are GO (IDLE to SEND on a launch write), AGAIN (SEND to SEND when another launch write arrives in the SEND cycle) and DONE (SEND to IDLE when no launch write arrives).

Top module: `audio_csr_ctrl`

## Requirements
- R1: After reset, every slot reads as zero, both channel enables are low, and no strobe, interrupt or error pulse is active.
- R2: A valid write to word index 1, 2, 3, 5, 6, 9 or 10 (byte address divided by four) stores all 32 bits, and a read of that index returns them in the same cycle on bus_rdata.
- R3: Index 0 is the codec control word. Bit 0 is launch and bit 1 is direction (1 = write). The stored value is the written value with bit 0 forced to 0.
- R4: A write to index 0 with bit 0 = 1 and bit 1 = 1 makes irq_req_sent high for exactly the one cycle after the write, and irq_rep_recv stays low.
- R5: A write to index 0 with bit 0 = 1 and bit 1 = 0 makes irq_rep_recv high for exactly the one cycle after the write, and irq_req_sent stays low.
- R6: In the cycle after a launch write, link_req_stb is high for one cycle. In that cycle link_req_wr equals the written bit 1, link_req_addr equals the low bits of index 1, and link_req_data equals the low bits of index 2.
- R7: A write to index 0 with bit 0 = 0 produces no strobe and no interrupt.
- R8: An access to index 7, or to any index of 11 or above, reads zero and leaves all stored state unchanged. bus_err pulses high in the following cycle.
- R9: An access that is not a full word is invalid, meaning bus_be is not 4'hF or the byte address has nonzero bits [1:0]. It reads zero, stores nothing, and pulses bus_err in the following cycle.
- R10: play_en follows bit 0 of index 4 and cap_en follows bit 0 of index 8, starting the cycle after the write.
- R11: When link_rep_stb is high, index 3 takes the zero-extended value of link_rep_data at that edge. This holds even if a bus write to index 3 happens in the same cycle.
- R12: Launch writes in consecutive cycles each produce their own strobe and interrupt pulse in consecutive cycles, each with its own direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; must all be set |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | One-cycle pulse after an invalid access |
| link_req_stb | output | 1 | Codec transaction request strobe |
| link_req_wr | output | 1 | Request direction, 1 = write |
| link_req_addr | output | 8 | Codec register address |
| link_req_data | output | 16 | Codec write data |
| link_rep_stb | input | 1 | Reply strobe from link |
| link_rep_data | input | 16 | Reply value from link |
| irq_req_sent | output | 1 | Request-sent interrupt pulse |
| irq_rep_recv | output | 1 | Reply interrupt pulse |
| play_en | output | 1 | Playback channel enable |
| cap_en | output | 1 | Capture channel enable |

## Verification
Two functions can land on the incoming-data slot in the same cycle: a bus write to index 3 and a link reply strobe. The bench raises both in one cycle with different values, then reads index 3 back and expects the link value. A second collision comes from launch writes in two consecutive cycles, where the SEND state must be entered again. The scoreboard expects two separate pulses, each with its own direction, one cycle apart.

// File: rtl/acsr_pkg.sv
package acsr_pkg;

    localparam int NUM_IDX = 11;
    localparam int IXW     = 4;

    localparam logic [IXW-1:0] IX_CCTRL = 4'd0;
    localparam logic [IXW-1:0] IX_CADDR = 4'd1;
    localparam logic [IXW-1:0] IX_DOUT  = 4'd2;
    localparam logic [IXW-1:0] IX_DIN   = 4'd3;
    localparam logic [IXW-1:0] IX_PCTRL = 4'd4;
    localparam logic [IXW-1:0] IX_PADDR = 4'd5;
    localparam logic [IXW-1:0] IX_PREM  = 4'd6;
    localparam logic [IXW-1:0] IX_RSVD  = 4'd7;
    localparam logic [IXW-1:0] IX_KCTRL = 4'd8;
    localparam logic [IXW-1:0] IX_KADDR = 4'd9;
    localparam logic [IXW-1:0] IX_KREM  = 4'd10;

    localparam int LAUNCH_BIT = 0;
    localparam int DIR_BIT    = 1;
    localparam int EN_BIT     = 0;

    typedef enum logic {
        L_IDLE = 1'b0,
        L_SEND = 1'b1
    } launch_state_t;

endpackage

// File: rtl/acsr_decode.sv
module acsr_decode
    import acsr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              rd_en,
    output logic [IXW-1:0]    idx,
    output logic              err
);
    localparam int WIW = ADDR_W - 2;

    logic [WIW-1:0] word_idx;
    logic           aligned;
    logic           full_word;
    logic           mapped;
    logic           ok;
    logic           err_q;

    assign word_idx  = addr[ADDR_W-1:2];
    assign aligned   = (addr[1:0] == 2'b00);
    assign full_word = &be;
    assign mapped    = (word_idx < WIW'(NUM_IDX)) && (word_idx != WIW'(IX_RSVD));
    assign ok        = sel && aligned && full_word && mapped;

    assign idx   = word_idx[IXW-1:0];
    assign wr_en = ok && we;
    assign rd_en = ok && !we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= sel && !ok;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/acsr_launch.sv
module acsr_launch
    import acsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic dir,
    output logic req_stb,
    output logic irq_sent,
    output logic irq_reply
);
    launch_state_t state_q;
    launch_state_t state_d;
    logic          dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= L_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                dir_q <= dir;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            L_IDLE: begin
                if (launch) begin
                    state_d = L_SEND;
                end
            end
            L_SEND: begin
                if (launch) begin
                    state_d = L_SEND;
                end else begin
                    state_d = L_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        req_stb   = 1'b0;
        irq_sent  = 1'b0;
        irq_reply = 1'b0;
        unique case (state_q)
            L_IDLE: begin
                req_stb = 1'b0;
            end
            L_SEND: begin
                req_stb   = 1'b1;
                irq_sent  = dir_q;
                irq_reply = !dir_q;
            end
        endcase
    end

    // R6
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> req_stb);

    // R12
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stb && !launch) |=> !req_stb);

endmodule

// File: rtl/acsr_regfile.sv
module acsr_regfile
    import acsr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CODEC_AW = 8,
    parameter int CODEC_DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [IXW-1:0]      idx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                rep_stb,
    input  logic [CODEC_DW-1:0] rep_data,
    output logic [DATA_W-1:0]   rdata,
    output logic                ctrl_dir,
    output logic [CODEC_AW-1:0] caddr,
    output logic [CODEC_DW-1:0] dout,
    output logic                play_en,
    output logic                cap_en
);
    localparam int PAD_W = DATA_W - CODEC_DW;

    logic [DATA_W-1:0] regs_q [NUM_IDX];
    logic [DATA_W-1:0] rep_word;

    assign rep_word = {{PAD_W{1'b0}}, rep_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IDX; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_IDX; i++) begin
                if (wr_en && (idx == IXW'(i)) && (IXW'(i) != IX_RSVD)) begin
                    if (IXW'(i) == IX_CCTRL) begin
                        regs_q[i] <= {wdata[DATA_W-1:1], 1'b0};
                    end else begin
                        regs_q[i] <= wdata;
                    end
                end
            end
            if (rep_stb) begin
                regs_q[IX_DIN] <= rep_word;
            end
        end
    end

    assign rdata    = rd_en ? regs_q[idx] : '0;
    assign ctrl_dir = regs_q[IX_CCTRL][DIR_BIT];
    assign caddr    = regs_q[IX_CADDR][CODEC_AW-1:0];
    assign dout     = regs_q[IX_DOUT][CODEC_DW-1:0];
    assign play_en  = regs_q[IX_PCTRL][EN_BIT];
    assign cap_en   = regs_q[IX_KCTRL][EN_BIT];

    // R8
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(regs_q[IX_CCTRL]) && $stable(regs_q[IX_CADDR])
                    && $stable(regs_q[IX_DOUT]) && $stable(regs_q[IX_PCTRL])
                    && $stable(regs_q[IX_KCTRL])));

    // R11
    reply_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_stb |=> (regs_q[IX_DIN] == {{PAD_W{1'b0}}, $past(rep_data)}));

endmodule

// File: rtl/audio_csr_ctrl.sv
module audio_csr_ctrl
    import acsr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CODEC_AW = 8,
    parameter int CODEC_DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_err,
    output logic                link_req_stb,
    output logic                link_req_wr,
    output logic [CODEC_AW-1:0] link_req_addr,
    output logic [CODEC_DW-1:0] link_req_data,
    input  logic                link_rep_stb,
    input  logic [CODEC_DW-1:0] link_rep_data,
    output logic                irq_req_sent,
    output logic                irq_rep_recv,
    output logic                play_en,
    output logic                cap_en
);
    localparam int BE_W = DATA_W / 8;

    logic           wr_en;
    logic           rd_en;
    logic [IXW-1:0] idx;
    logic           launch;

    acsr_decode #(
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W)
    ) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .we    (bus_we),
        .be    (bus_be),
        .addr  (bus_addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .idx   (idx),
        .err   (bus_err)
    );

    acsr_regfile #(
        .DATA_W   (DATA_W),
        .CODEC_AW (CODEC_AW),
        .CODEC_DW (CODEC_DW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .idx      (idx),
        .wdata    (bus_wdata),
        .rep_stb  (link_rep_stb),
        .rep_data (link_rep_data),
        .rdata    (bus_rdata),
        .ctrl_dir (link_req_wr),
        .caddr    (link_req_addr),
        .dout     (link_req_data),
        .play_en  (play_en),
        .cap_en   (cap_en)
    );

    assign launch = wr_en && (idx == IX_CCTRL) && bus_wdata[LAUNCH_BIT];

    acsr_launch u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .dir       (bus_wdata[DIR_BIT]),
        .req_stb   (link_req_stb),
        .irq_sent  (irq_req_sent),
        .irq_reply (irq_rep_recv)
    );

    // R4
    sent_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_sent |-> (link_req_wr && link_req_stb));

    // R5
    reply_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rep_recv |-> (!link_req_wr && link_req_stb));

    // R10
    play_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_PCTRL) |=> (play_en == $past(bus_wdata[EN_BIT])));

    // R9
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !(&bus_be)) |=> !link_req_stb || $past(link_req_stb));

endmodule

// File: tb/tb_audio_csr_ctrl.sv
module tb_audio_csr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        link_req_stb;
    logic        link_req_wr;
    logic [7:0]  link_req_addr;
    logic [15:0] link_req_data;
    logic        link_rep_stb = 1'b0;
    logic [15:0] link_rep_data = 16'h0;
    logic        irq_req_sent;
    logic        irq_rep_recv;
    logic        play_en;
    logic        cap_en;

    always #2 clk = ~clk;

    audio_csr_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_we        (bus_we),
        .bus_be        (bus_be),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_err       (bus_err),
        .link_req_stb  (link_req_stb),
        .link_req_wr   (link_req_wr),
        .link_req_addr (link_req_addr),
        .link_req_data (link_req_data),
        .link_rep_stb  (link_rep_stb),
        .link_rep_data (link_rep_data),
        .irq_req_sent  (irq_req_sent),
        .irq_rep_recv  (irq_rep_recv),
        .play_en       (play_en),
        .cap_en        (cap_en)
    );

    typedef struct {
        int          cyc;
        logic [3:0]  p;     // {req_stb, irq_sent, irq_reply, err}
        logic [31:0] aux;   // {7'b0, req_wr, req_addr, req_data}
        string       tag;
    } item_t;

    item_t       sb[$];
    item_t       cur;
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [31:0] mdl [11];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].cyc == cyc) begin
                cur = sb.pop_front();
                chk({link_req_stb, irq_req_sent, irq_rep_recv, bus_err} == cur.p, cur.tag,
                    "pulses", {28'h0, link_req_stb, irq_req_sent, irq_rep_recv, bus_err},
                    {28'h0, cur.p});
                if (cur.p[3]) begin
                    chk({7'h0, link_req_wr, link_req_addr, link_req_data} == cur.aux, "R6",
                        "request fields", {7'h0, link_req_wr, link_req_addr, link_req_data},
                        cur.aux);
                end
            end else if ({link_req_stb, irq_req_sent, irq_rep_recv, bus_err} != 4'h0) begin
                chk(1'b0, "R7", "unexpected pulse",
                    {28'h0, link_req_stb, irq_req_sent, irq_rep_recv, bus_err}, 32'h0);
            end
        end
    end

    function automatic bit is_valid(input logic [7:0] a, input logic [3:0] be);
        return (a[1:0] == 2'b00) && (be == 4'hF) && ((a >> 2) < 11) && ((a >> 2) != 7);
    endfunction

    task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d,
                          input logic [3:0] be, input string tag);
        item_t it;
        bit    v;
        int    ix;
        @(negedge clk);
        v  = is_valid(a, be);
        ix = int'(a >> 2);
        bus_sel   = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        bus_be    = be;
        if (!v) begin
            it = '{cyc + 1, 4'b0001, 32'h0, tag};
            sb.push_back(it);
        end else if (we) begin
            mdl[ix] = (ix == 0) ? {d[31:1], 1'b0} : d;
            if (ix == 0 && d[0]) begin
                it = '{cyc + 1, {1'b1, d[1], !d[1], 1'b0},
                       {7'h0, d[1], mdl[1][7:0], mdl[2][15:0]}, tag};
                sb.push_back(it);
            end
        end
        if (!we) begin
            #1;
            chk(bus_rdata == (v ? mdl[ix] : 32'h0), tag, "read data", bus_rdata,
                v ? mdl[ix] : 32'h0);
        end
        @(negedge clk);
        bus_sel = 1'b0;
        bus_we  = 1'b0;
        bus_be  = 4'h0;
    endtask

    task automatic wr(input int ix, input logic [31:0] d, input string tag);
        access(1'b1, 8'(ix * 4), d, 4'hF, tag);
    endtask

    task automatic rd(input int ix, input string tag);
        access(1'b0, 8'(ix * 4), 32'h0, 4'hF, tag);
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            chk(1'b0, "WD", "watchdog expired", 32'(cyc), 32'h0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        item_t it;
        for (int i = 0; i < 11; i++) mdl[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk({link_req_stb, irq_req_sent, irq_rep_recv, bus_err, play_en, cap_en} == 6'h0,
            "R1", "outputs after reset",
            {26'h0, link_req_stb, irq_req_sent, irq_rep_recv, bus_err, play_en, cap_en}, 32'h0);
        for (int i = 0; i < 11; i++) begin
            if (i != 7) rd(i, "R1");
        end

        // R2: storage and readback
        wr(1, 32'hDEAD_BE5A, "R2");
        wr(2, 32'h1234_C0DE, "R2");
        wr(5, 32'hFFFF_FFFF, "R2");
        wr(6, 32'h0000_0001, "R2");
        wr(9, 32'h8000_0000, "R2");
        wr(10, 32'h5555_AAAA, "R2");
        wr(3, 32'h0F0F_0F0F, "R2");
        rd(1, "R2"); rd(2, "R2"); rd(5, "R2"); rd(6, "R2");
        rd(9, "R2"); rd(10, "R2"); rd(3, "R2");

        // R3 + R4 + R6: write launch, stored without launch bit
        wr(0, 32'hA5A5_5AF3, "R4");
        rd(0, "R3");

        // R7: no launch bit
        wr(0, 32'h0000_0002, "R7");
        chk(!link_req_stb && !irq_req_sent && !irq_rep_recv, "R7", "no pulse",
            {29'h0, link_req_stb, irq_req_sent, irq_rep_recv}, 32'h0);
        rd(0, "R3");

        // R5: read launch with new address/data
        wr(1, 32'h0000_0042, "R6");
        wr(2, 32'h0000_7777, "R6");
        wr(0, 32'h0000_0001, "R5");
        rd(0, "R3");

        // R12: back-to-back launches
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_be = 4'hF; bus_addr = 8'h00;
        bus_wdata = 32'h0000_0003;
        it = '{cyc + 1, 4'b1100, {7'h0, 1'b1, mdl[1][7:0], mdl[2][15:0]}, "R12"};
        sb.push_back(it);
        @(negedge clk);
        bus_wdata = 32'h0000_0001;
        it = '{cyc + 1, 4'b1010, {7'h0, 1'b0, mdl[1][7:0], mdl[2][15:0]}, "R12"};
        sb.push_back(it);
        mdl[0] = 32'h0;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
        rd(0, "R12");

        // R8: reserved and out-of-range
        access(1'b1, 8'h1C, 32'hFFFF_FFFF, 4'hF, "R8");
        access(1'b0, 8'h1C, 32'h0, 4'hF, "R8");
        access(1'b1, 8'h30, 32'h1111_1111, 4'hF, "R8");
        access(1'b0, 8'hFC, 32'h0, 4'hF, "R8");
        access(1'b1, 8'h00, 32'h0000_0003, 4'hF, "R8");  // valid launch between
        access(1'b1, 8'h2C, 32'h0000_0001, 4'hF, "R8");
        rd(0, "R8"); rd(1, "R8"); rd(10, "R8");

        // R9: partial and misaligned
        access(1'b1, 8'h04, 32'h0000_00FF, 4'b0011, "R9");
        access(1'b1, 8'h05, 32'h0000_0099, 4'hF, "R9");
        access(1'b0, 8'h08, 32'h0, 4'b1110, "R9");
        access(1'b1, 8'h00, 32'h0000_0001, 4'b0001, "R9");
        rd(1, "R9"); rd(0, "R9");

        // R10: channel enables
        wr(4, 32'h0000_0001, "R10");
        chk(play_en && !cap_en, "R10", "play on", {30'h0, play_en, cap_en}, 32'h2);
        wr(8, 32'hFFFF_FFFF, "R10");
        chk(play_en && cap_en, "R10", "both on", {30'h0, play_en, cap_en}, 32'h3);
        wr(4, 32'hFFFF_FFFE, "R10");
        chk(!play_en && cap_en, "R10", "play off", {30'h0, play_en, cap_en}, 32'h1);
        rd(4, "R10"); rd(8, "R10");

        // R11: reply alone, then reply colliding with bus write
        @(negedge clk);
        link_rep_stb = 1'b1; link_rep_data = 16'h1234;
        @(negedge clk);
        link_rep_stb = 1'b0;
        mdl[3] = 32'h0000_1234;
        rd(3, "R11");
        @(negedge clk);
        link_rep_stb = 1'b1; link_rep_data = 16'hBEEF;
        bus_sel = 1'b1; bus_we = 1'b1; bus_be = 4'hF; bus_addr = 8'h0C;
        bus_wdata = 32'h1357_9BDF;
        @(negedge clk);
        link_rep_stb = 1'b0;
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'h0;
        mdl[3] = 32'h0000_BEEF;
        rd(3, "R11");
        wr(3, 32'h0000_0ABC, "R11");
        rd(3, "R11");

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R12", "scoreboard drained", 32'(sb.size()), 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule